// File: doc/BRIEF.md
# Tetrahedral L\*a\*b\* to CMYK Colour Converter

This block turns a stream of 24-bit L\*a\*b\* pixels into 32-bit CMYK pixels, accepting one pixel per clock. Each of the four output colorants has its own coarse lattice table. The lattice has sixteen nodes per axis, one every sixteen input codes. For every pixel the upper four bits of each channel pick the enclosing lattice cell, and the lower four bits give the fractional offset inside that cell. The order of the three offsets by size selects one of six tetrahedra that split the cell. The four corner values of that tetrahedron are blended with offset-derived weights to give each colorant.

Software fills the tables through a simple write port while no pixels are moving. Each table is stored as eight parity banks, so that all eight corners of a cell can be read in the same cycle. Pixels enter and leave through valid/ready handshakes. One stall signal covers a two-stage pipeline: stage one is the table read, stage two is the blend and output register.

Top module: `tetra_color_conv`

## Requirements
- R1: With rst high at a clock edge (synchronous, active high), out_valid is 0 after that edge. Once reset is released, in_ready is 1 while the output is empty.
- R2: in_pix packs L in bits 23:16, a in 15:8 and b in 7:0. out_pix packs C in 31:24, M in 23:16, Y in 15:8 and K in 7:0. The cell index on each axis is the channel's upper four bits, and the table entry address is Lnode*256 + anode*16 + bnode. A pixel whose three low nibbles are zero returns, for each plane, exactly the entry at its own node.
- R3: With offsets sorted so that f1 >= f2 >= f3, the corner path starts at the cell's low corner v0. It then steps along the axis of f1 to reach v1, along the axis of f2 to reach v2, and along the last axis to reach the far corner v3. Each plane equals floor((v0*(16-f1) + v1*(f1-f2) + v2*(f2-f3) + v3*f3 + 8) / 16), limited to 255. Equal offsets may pick either order, because the result is the same.
- R4: On any axis whose cell index is 15, the upper corner uses node 15 again. Channel values 240..255 on that axis therefore all read the node-15 entries.
- R5: A pixel accepted at a clock edge appears on out_valid/out_pix two edges later when out_ready is held high. Back-to-back pixels are accepted and delivered one per clock, in order.
- R6: in_ready equals (!out_valid || out_ready). While out_valid is high and out_ready is low, out_pix and out_valid hold their values.
- R7: A table write (wr_en high at an edge) takes effect only if in_valid is low at that edge and no accepted pixel is still inside the block. Otherwise the write is dropped and the table keeps its previous contents.
- R8: wr_plane selects the table: 0 is C, 1 is M, 2 is Y, 3 is K. wr_idx uses the address layout of R2. A write changes only that one entry of that one plane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel offered |
| in_ready | output | 1 | Block can take a pixel this edge |
| in_pix | input | 24 | L\*a\*b\* pixel: L, a, b from top byte down |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream takes the output this edge |
| out_pix | output | 32 | CMYK pixel: C, M, Y, K from top byte down |
| wr_en | input | 1 | Table write request |
| wr_plane | input | 2 | Target table: 0 C, 1 M, 2 Y, 3 K |
| wr_idx | input | 12 | Lattice entry address (L node, a node, b node) |
| wr_data | input | 8 | Entry value |

## Verification
A parity-bank mapping error or a wrong corner step sends the wrong lattice values to one colorant only. This shows as a byte mismatch on out_pix two cycles after the pixel enters, and only for pixels whose cell touches the faulty bank or whose offset ordering takes that path. The stimulus therefore covers every offset ordering, ties, both clamped and unclamped top cells, and random pixels that reach all eight banks. A stall-control fault breaks the ready rule or the held output in the very cycle it happens. A write-gating fault stays hidden until the affected entry is read back on a later on-grid pixel.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    // Default geometry: 8-bit channels, 16 lattice nodes per axis
    localparam int CH_W    = 8;
    localparam int NODE_W  = 4;
    localparam int PLANES  = 4;
    localparam int CORNERS = 8;

    // One-hot tetrahedron code, named by the axis order of the corner path
    typedef enum logic [5:0] {
        TET_LAB = 6'b000001,
        TET_LBA = 6'b000010,
        TET_BLA = 6'b000100,
        TET_ALB = 6'b001000,
        TET_ABL = 6'b010000,
        TET_BAL = 6'b100000
    } tet_e;

    // Offset ordering picks the tetrahedron; ties go to the earlier code
    function automatic tet_e tet_pick(int unsigned x, int unsigned y, int unsigned z);
        if (x >= y && y >= z)      return TET_LAB;
        else if (x >= z && z > y)  return TET_LBA;
        else if (z > x && x >= y)  return TET_BLA;
        else if (y > x && x >= z)  return TET_ALB;
        else if (y >= z && z > x)  return TET_ABL;
        else                       return TET_BAL;
    endfunction

    // Corner index layout: bit2 = L step, bit1 = a step, bit0 = b step
    function automatic logic [2:0] corner_id(logic l, logic a, logic b);
        return {l, a, b};
    endfunction

endpackage

// File: rtl/tcc_bank_ram.sv
module tcc_bank_ram #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic          re,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rq
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
        if (re) rq <= mem[ra];
    end
endmodule

// File: rtl/tcc_plane_store.sv
module tcc_plane_store
    import tcc_pkg::*;
#(
    parameter int CH_W   = tcc_pkg::CH_W,
    parameter int NODE_W = tcc_pkg::NODE_W
) (
    input  logic                           clk,
    input  logic                           rd_en,
    input  logic [NODE_W-1:0]              l_node,
    input  logic [NODE_W-1:0]              a_node,
    input  logic [NODE_W-1:0]              b_node,
    input  logic                           wr_en,
    input  logic [3*NODE_W-1:0]            wr_idx,
    input  logic [CH_W-1:0]                wr_data,
    output logic [CORNERS-1:0][CH_W-1:0]   corner
);
    localparam int HALF_W = NODE_W - 1;
    localparam int BANK_AW = 3 * HALF_W;
    localparam logic [NODE_W-1:0] TOP = {NODE_W{1'b1}};

    logic [NODE_W-1:0] wl, wa, wb;
    logic [BANK_AW-1:0] w_addr;
    logic [2:0] w_bank;
    logic [CORNERS-1:0][CH_W-1:0] bank_q;

    // Parity and clamp state of the cell read in flight
    logic par_l, par_a, par_b;
    logic top_l, top_a, top_b;

    assign wl = wr_idx[3*NODE_W-1 -: NODE_W];
    assign wa = wr_idx[2*NODE_W-1 -: NODE_W];
    assign wb = wr_idx[NODE_W-1:0];
    assign w_bank = corner_id(wl[0], wa[0], wb[0]);
    assign w_addr = {wl[NODE_W-1:1], wa[NODE_W-1:1], wb[NODE_W-1:1]};

    for (genvar k = 0; k < CORNERS; k++) begin : g_bank
        localparam int PL = (k / 4) % 2;
        localparam int PA = (k / 2) % 2;
        localparam int PB = k % 2;
        logic [NODE_W-1:0] lc, ac, bc;
        logic [BANK_AW-1:0] r_addr;

        // The bank of parity P holds whichever of node and node+1 has parity P
        assign lc = (l_node[0] == PL[0]) ? l_node : l_node + 1'b1;
        assign ac = (a_node[0] == PA[0]) ? a_node : a_node + 1'b1;
        assign bc = (b_node[0] == PB[0]) ? b_node : b_node + 1'b1;
        assign r_addr = {lc[NODE_W-1:1], ac[NODE_W-1:1], bc[NODE_W-1:1]};

        tcc_bank_ram #(.AW(BANK_AW), .DW(CH_W)) u_ram (
            .clk (clk),
            .we  (wr_en && (w_bank == 3'(k))),
            .wa  (w_addr),
            .wd  (wr_data),
            .re  (rd_en),
            .ra  (r_addr),
            .rq  (bank_q[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            par_l <= l_node[0];
            par_a <= a_node[0];
            par_b <= b_node[0];
            top_l <= (l_node == TOP);
            top_a <= (a_node == TOP);
            top_b <= (b_node == TOP);
        end
    end

    // Route each cube corner to the bank that served it; clamped axes reuse the low node
    always_comb begin
        for (int c = 0; c < CORNERS; c++) begin
            logic sl, sa, sb;
            sl = top_l ? par_l : (par_l ^ c[2]);
            sa = top_a ? par_a : (par_a ^ c[1]);
            sb = top_b ? par_b : (par_b ^ c[0]);
            corner[c] = bank_q[corner_id(sl, sa, sb)];
        end
    end
endmodule

// File: rtl/tcc_tet_blend.sv
module tcc_tet_blend
    import tcc_pkg::*;
#(
    parameter int CH_W   = tcc_pkg::CH_W,
    parameter int FRAC_W = tcc_pkg::CH_W - tcc_pkg::NODE_W
) (
    input  logic [CORNERS-1:0][CH_W-1:0] corner,
    input  logic [FRAC_W-1:0]            lf,
    input  logic [FRAC_W-1:0]            af,
    input  logic [FRAC_W-1:0]            bf,
    output tet_e                         sel,
    output logic [CH_W-1:0]              value
);
    localparam int W_W   = FRAC_W + 1;
    localparam int ACC_W = CH_W + FRAC_W + 2;
    localparam int ONE   = 1 << FRAC_W;
    localparam int HALF  = 1 << (FRAC_W - 1);
    localparam int MAXV  = (1 << CH_W) - 1;
    localparam logic [2:0] C_LOW = 3'b000;
    localparam logic [2:0] C_FAR = 3'b111;

    logic [2:0]        i1, i2;
    logic [FRAC_W-1:0] f1, f2, f3;
    logic [W_W-1:0]    w0, w1, w2, w3;
    logic [ACC_W-1:0]  acc, rnd, q;

    assign sel = tet_pick(32'(lf), 32'(af), 32'(bf));

    // Corner path: low corner, one step along the largest offset, then the next
    always_comb begin
        unique case (sel)
            TET_LAB: begin i1 = 3'b100; i2 = 3'b110; f1 = lf; f2 = af; f3 = bf; end
            TET_LBA: begin i1 = 3'b100; i2 = 3'b101; f1 = lf; f2 = bf; f3 = af; end
            TET_BLA: begin i1 = 3'b001; i2 = 3'b101; f1 = bf; f2 = lf; f3 = af; end
            TET_ALB: begin i1 = 3'b010; i2 = 3'b110; f1 = af; f2 = lf; f3 = bf; end
            TET_ABL: begin i1 = 3'b010; i2 = 3'b011; f1 = af; f2 = bf; f3 = lf; end
            TET_BAL: begin i1 = 3'b001; i2 = 3'b011; f1 = bf; f2 = af; f3 = lf; end
            default: begin i1 = 3'b100; i2 = 3'b110; f1 = lf; f2 = af; f3 = bf; end
        endcase
    end

    always_comb begin
        w0 = W_W'(ONE) - {1'b0, f1};
        w1 = {1'b0, f1} - {1'b0, f2};
        w2 = {1'b0, f2} - {1'b0, f3};
        w3 = {1'b0, f3};
        acc = ACC_W'(corner[C_LOW]) * ACC_W'(w0)
            + ACC_W'(corner[i1])    * ACC_W'(w1)
            + ACC_W'(corner[i2])    * ACC_W'(w2)
            + ACC_W'(corner[C_FAR]) * ACC_W'(w3);
        rnd = acc + ACC_W'(HALF);
        q   = rnd >> FRAC_W;
        value = (q > ACC_W'(MAXV)) ? CH_W'(MAXV) : q[CH_W-1:0];
    end
endmodule

// File: rtl/tetra_color_conv.sv
module tetra_color_conv
    import tcc_pkg::*;
#(
    parameter int CH_W   = tcc_pkg::CH_W,
    parameter int NODE_W = tcc_pkg::NODE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [3*CH_W-1:0]    in_pix,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [4*CH_W-1:0]    out_pix,
    input  logic                 wr_en,
    input  logic [1:0]           wr_plane,
    input  logic [3*NODE_W-1:0]  wr_idx,
    input  logic [CH_W-1:0]      wr_data
);
    localparam int FRAC_W = CH_W - NODE_W;
    localparam int OUT_W  = PLANES * CH_W;

    typedef struct packed {
        logic              valid;
        logic [FRAC_W-1:0] lf;
        logic [FRAC_W-1:0] af;
        logic [FRAC_W-1:0] bf;
    } stage1_t;

    logic adv, wr_ok;
    logic [NODE_W-1:0] l_node, a_node, b_node;
    stage1_t s1;
    logic [PLANES-1:0][CORNERS-1:0][CH_W-1:0] corners;
    logic [PLANES-1:0][CH_W-1:0] plane_val;
    tet_e [PLANES-1:0] tet_sel;
    logic [OUT_W-1:0] out_nxt;

    // One stall signal moves both stages together
    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    assign l_node = in_pix[3*CH_W-1 -: NODE_W];
    assign a_node = in_pix[2*CH_W-1 -: NODE_W];
    assign b_node = in_pix[CH_W-1 -: NODE_W];

    // Table loads only with nothing offered and nothing in flight
    assign wr_ok = wr_en && !in_valid && !s1.valid && !out_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else if (adv) begin
            s1.valid <= in_valid;
            s1.lf    <= in_pix[2*CH_W +: FRAC_W];
            s1.af    <= in_pix[CH_W +: FRAC_W];
            s1.bf    <= in_pix[0 +: FRAC_W];
        end
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        tcc_plane_store #(.CH_W(CH_W), .NODE_W(NODE_W)) u_store (
            .clk     (clk),
            .rd_en   (adv),
            .l_node  (l_node),
            .a_node  (a_node),
            .b_node  (b_node),
            .wr_en   (wr_ok && (wr_plane == 2'(p))),
            .wr_idx  (wr_idx),
            .wr_data (wr_data),
            .corner  (corners[p])
        );

        tcc_tet_blend #(.CH_W(CH_W), .FRAC_W(FRAC_W)) u_blend (
            .corner (corners[p]),
            .lf     (s1.lf),
            .af     (s1.af),
            .bf     (s1.bf),
            .sel    (tet_sel[p]),
            .value  (plane_val[p])
        );

        // Plane 0 (C) sits in the top byte
        assign out_nxt[(PLANES-1-p)*CH_W +: CH_W] = plane_val[p];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else if (adv) begin
            out_valid <= s1.valid;
            if (s1.valid) out_pix <= out_nxt;
        end
    end
endmodule

// File: rtl/tetra_color_conv_chk.sv
module tetra_color_conv_chk #(
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_pix
);
    logic [2:0] inflight;
    logic       rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) inflight <= '0;
        else     inflight <= inflight + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
    end

    always @(posedge clk) begin
        if (rst_q === 1'b1 && rst === 1'b0)
            AST_RST_IDLE: assert (!out_valid) else $error("output valid right after reset"); // R1
    end

    AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) ##1 out_ready |=> out_valid); // R5

    AST_INFLIGHT_MAX: assert property (@(posedge clk) disable iff (rst)
        inflight <= 3'd2); // R5

    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> inflight != 3'd0); // R5

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix))); // R6

    AST_READY_FREE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready); // R6
endmodule

bind tetra_color_conv tetra_color_conv_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix)
);

// File: tb/tb_tetra_color_conv.sv
`timescale 1ns/1ps
module tb_tetra_color_conv;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_pix = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_pix;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_plane = '0;
    logic [11:0] wr_idx = '0;
    logic [7:0]  wr_data = '0;

    always #2.5 clk = ~clk;   // 200 MHz

    tetra_color_conv dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
        .wr_en(wr_en), .wr_plane(wr_plane), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    int    tbl [4][4096];
    int    exp_q[$];
    int    cyc_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    lat_chk = 1'b0;
    bit    rand_rdy = 1'b0;
    bit    was_stall = 1'b0;
    logic [31:0] held_pix;
    string cur_req = "R1";

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, expv, $time);
        end
    endtask

    function automatic int tv(int p, int i);
        return ((i * 37 + p * 91 + (i >> 7) * 13) ^ (i >> 3)) & 255;
    endfunction

    // Node lookup with top-cell clamp (R4)
    function automatic int node(int p, int l, int a, int b);
        if (l > 15) l = 15;
        if (a > 15) a = 15;
        if (b > 15) b = 15;
        return tbl[p][l * 256 + a * 16 + b];
    endfunction

    // Tetrahedral blend from the requirement text (R3)
    function automatic int ref_plane(int p, int px);
        int n0, n1, n2, f0, f1, f2;
        int o0, o1, o2, t, acc;
        int c0, c1, c2, v0, v1, v2, v3;
        n0 = (px >> 20) & 15; f0 = (px >> 16) & 15;
        n1 = (px >> 12) & 15; f1 = (px >> 8) & 15;
        n2 = (px >> 4) & 15;  f2 = px & 15;
        o0 = 0; o1 = 1; o2 = 2;
        if ((o1 == 1 ? f1 : f0) > f0) begin t = o0; o0 = o1; o1 = t; end
        if (((o2 == 2) ? f2 : 0) > ((o1 == 0) ? f0 : f1)) begin t = o1; o1 = o2; o2 = t; end
        if (((o1 == 0) ? f0 : (o1 == 1) ? f1 : f2) > ((o0 == 0) ? f0 : (o0 == 1) ? f1 : f2)) begin
            t = o0; o0 = o1; o1 = t;
        end
        c0 = 0; c1 = 0; c2 = 0;
        v0 = node(p, n0, n1, n2);
        if (o0 == 0) c0 = 1; else if (o0 == 1) c1 = 1; else c2 = 1;
        v1 = node(p, n0 + c0, n1 + c1, n2 + c2);
        if (o1 == 0) c0 = 1; else if (o1 == 1) c1 = 1; else c2 = 1;
        v2 = node(p, n0 + c0, n1 + c1, n2 + c2);
        v3 = node(p, n0 + 1, n1 + 1, n2 + 1);
        begin
            int g0, g1, g2;
            g0 = (o0 == 0) ? f0 : (o0 == 1) ? f1 : f2;
            g1 = (o1 == 0) ? f0 : (o1 == 1) ? f1 : f2;
            g2 = (o2 == 0) ? f0 : (o2 == 1) ? f1 : f2;
            acc = v0 * (16 - g0) + v1 * (g0 - g1) + v2 * (g1 - g2) + v3 * g2;
        end
        t = (acc + 8) / 16;
        if (t > 255) t = 255;
        return t;
    endfunction

    function automatic logic [31:0] ref_pix(int px);
        logic [31:0] r = '0;
        for (int p = 0; p < 4; p++) r[(3 - p) * 8 +: 8] = 8'(ref_plane(p, px));
        return r;
    endfunction

    // Downstream readiness
    always @(negedge clk) begin
        #1;
        out_ready = rand_rdy ? ($urandom_range(0, 3) != 0) : 1'b1;
    end

    // Cycle monitor and reference model, sampled between edges
    always @(negedge clk) begin
        #2;
        cyc++;
        if (!rst) begin
            chk("R6", {31'd0, in_ready}, {31'd0, (!out_valid || out_ready)});
            if (was_stall) begin
                chk("R6", {31'd0, out_valid}, 32'd1);
                chk("R6", out_pix, held_pix);
            end
            was_stall = out_valid && !out_ready;
            held_pix  = out_pix;
            // R7: model drops writes while anything is offered or in flight
            if (wr_en && !in_valid && exp_q.size() == 0)
                tbl[wr_plane][wr_idx] = int'(wr_data);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL %s: actual %h expected none (unrequested output)", cur_req, out_pix);
                end else begin
                    int c;
                    chk(cur_req, out_pix, 32'(exp_q.pop_front()));
                    c = cyc_q.pop_front();
                    if (lat_chk) chk("R5", 32'(cyc - c), 32'd2);
                end
            end
            if (in_valid && in_ready) begin
                exp_q.push_back(int'(ref_pix(int'(in_pix))));
                cyc_q.push_back(cyc);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(int p, int i, int d);
        wr_en = 1'b1; wr_plane = 2'(p); wr_idx = 12'(i); wr_data = 8'(d);
        step();
        wr_en = 1'b0;
    endtask

    task automatic send(logic [23:0] px);
        logic acc;
        in_valid = 1'b1;
        in_pix = px;
        do begin
            #1;
            acc = in_ready;
            step();
        end while (!acc);
    endtask

    task automatic drain();
        in_valid = 1'b0;
        for (int k = 0; k < 50 && exp_q.size() != 0; k++) step();
        step();
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        report();
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1: idle after reset
        chk("R1", {31'd0, out_valid}, 32'd0);
        chk("R1", {31'd0, in_ready}, 32'd1);

        // R8: load all four planes
        cur_req = "R8";
        for (int p = 0; p < 4; p++)
            for (int i = 0; i < 4096; i++) wr(p, i, tv(p, i));

        // R2: on-grid pixels return the node entry
        cur_req = "R2";
        send(24'h000000); send(24'hF0F0F0); send(24'h305070);
        send(24'hF000A0); send(24'h10E060); send(24'hA0A0A0);
        drain();
        chk("R2", {31'd0, out_valid}, 32'd0);

        // R3: every offset ordering, plus ties
        cur_req = "R3";
        send(24'hC9D582); send(24'hC9D285); send(24'hC5D289);
        send(24'hC5D982); send(24'hC2D985); send(24'hC2D589);
        send(24'h777773); send(24'h473377); send(24'h230707);
        send(24'h666666); send(24'h5F9FAF); send(24'h011000);
        drain();

        // R4: top-cell clamp on one, two and three axes
        cur_req = "R4";
        send(24'hFFF8F3); send(24'h10FF27); send(24'hFFFFFF);
        send(24'hF705FF); send(24'hF0F0F0); send(24'hF8FCF4);
        drain();

        // R5: back-to-back stream, two-cycle latency
        cur_req = "R5";
        lat_chk = 1'b1;
        for (int k = 0; k < 24; k++) send(24'($urandom));
        drain();
        lat_chk = 1'b0;

        // R6: random backpressure and input gaps
        cur_req = "R6";
        rand_rdy = 1'b1;
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(0, 3) == 0) begin in_valid = 1'b0; step(); end
            send(24'($urandom));
        end
        drain();
        rand_rdy = 1'b0;
        drain();

        // R7: writes while offered or in flight are dropped
        cur_req = "R7";
        wr_en = 1'b1; wr_plane = 2'd1; wr_idx = 12'h123; wr_data = 8'hAA;
        send(24'h102030);
        wr_en = 1'b0;
        send(24'h405060);
        in_valid = 1'b0;
        wr(1, 12'h123, 8'h55);
        wr(3, 12'h123, 8'h66);
        drain();
        send(24'h102030);
        drain();

        // R8: one write touches one plane entry only
        cur_req = "R8";
        wr(2, 12'h456, 8'h5A);
        send(24'h405060);
        send(24'h405160);
        drain();

        report();
        $finish;
    end
endmodule